// File: doc/BRIEF.md
# Programmable XOR-Equation Metadata Address Generator

This block turns a pixel coordinate (x, y, z, sample) into the byte address of the metadata element that covers it, together with a nibble position inside that byte. How the address bits are formed is not hardwired. Each bit of a raw address is the parity of up to five coordinate bits, and those bits are chosen by an equation table that software loads through a small write port. One of the selectable coordinates is the linear index of the metadata block that holds the pixel. That index is computed from the block dimensions, the metadata pitch and the metadata height. The uppermost equation bit is the exception: it and every bit above it are filled with the block index, shifted right. The raw address is then shifted right by one bit. A pipe XOR pattern, masked to a programmable number of bits and placed at a programmable interleave position, is XORed into the shifted address. The bit dropped by the shift becomes the nibble position.

A request is presented for a single cycle with a valid strobe. The result appears one clock later with its own valid flag and holds its value until the next request.

Top module: `meta_addr_gen`

## Requirements
- R1: A table write occurs when `eq_we_i` is high. It stores `eq_word_i` into the term numbered `eq_term_i` (0..4) of the equation bit numbered `eq_bit_i`. The selector is word[15:8] and the ordinal is word[7:0]. A write whose term number is 5..7 changes nothing. After reset every term holds selector 255, ordinal 0.
- R2: A table write in a cycle where `in_valid_i` is high is ignored, and that request uses the table contents from before the write.
- R3: The block index is zb*((height>>hlog2)*(pitch>>wlog2)) + yb*(pitch>>wlog2) + xb, taken modulo 2^32, where xb, yb and zb are x>>wlog2, y>>hlog2 and z>>dlog2.
- R4: For each bit b below nb-1, raw bit b is the XOR of the selected coordinate bits. The selectors are 0=x, 1=y, 2=z, 3=sample and 4=block index. A term with a selector of 5 or more, or with an ordinal of 32 or more, contributes 0.
- R5: Raw bits nb-1 and up are (block index >> ordinal of term 0 of bit nb-1) << (nb-1), truncated to 32 bits. The selector of that term is not used.
- R6: `nibble_o` is 4 when raw bit 0 is 1, and 0 otherwise.
- R7: `addr_o` = (raw >> 1) XOR ((pipe_xor AND mask) << (8 + interleave)). The mask keeps the low `pipe_bits_i` bits, or all 8 bits when `pipe_bits_i` is 8 or more.
- R8: `out_valid_o` equals `in_valid_i` from the previous clock. `addr_o` and `nibble_o` update only after a request and hold otherwise.
- R9: While `rst_ni` is low, `out_valid_o`, `addr_o` and `nibble_o` are 0.
- R10: The effective bit count nb is `num_bits_i` limited to 1..32. A value of 0 acts as 1, and values above 32 act as 32.
- R11: Take an equation in which raw bit 1 uses only sample bit 0, raw bit 0 does not use the sample, and nb is at least 3. Under that equation, sample 1 of a pixel addresses exactly one byte after sample 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| eq_we_i | input | 1 | Equation table write strobe |
| eq_bit_i | input | 5 | Equation bit being written |
| eq_term_i | input | 3 | Term slot being written (0..4) |
| eq_word_i | input | 16 | Term word: selector [15:8], ordinal [7:0] |
| in_valid_i | input | 1 | Request strobe |
| x_i | input | 16 | Pixel x |
| y_i | input | 16 | Pixel y |
| z_i | input | 16 | Slice |
| sample_i | input | 16 | Sample number |
| blk_w_log2_i | input | 4 | log2 of metadata block width |
| blk_h_log2_i | input | 4 | log2 of metadata block height |
| blk_d_log2_i | input | 4 | log2 of metadata block depth |
| pitch_i | input | 16 | Metadata pitch in pixels |
| height_i | input | 16 | Metadata height in pixels |
| pipe_xor_i | input | 8 | Pipe XOR pattern |
| pipe_bits_i | input | 4 | Number of pipe XOR bits kept |
| ilv_i | input | 3 | Interleave field (shift is 8 + value) |
| num_bits_i | input | 6 | Equation bit count |
| out_valid_o | output | 1 | Result valid |
| addr_o | output | 32 | Metadata byte address |
| nibble_o | output | 3 | Nibble position (0 or 4) |

## Verification
The bench builds the block with its defaults: 32 equation bits, 16-bit coordinates and an 8-bit pipe pattern. With these values the full ordinal range and the widest top-bit shift are reachable. Pipe bit counts both below and beyond the pattern width can be applied, along with interleave shifts that push pipe bits up to address bit 22. A 32-bit equation loaded with random terms makes the block index feed low bits at high ordinals, where the product wraps. A hand-written short equation is swept over every coordinate of a small surface to exercise the sample-adjacency property.

// File: rtl/meta_addr_pkg.sv
package meta_addr_pkg;
  localparam int unsigned TERMS    = 5;
  localparam int unsigned FIELD_W  = 8;
  localparam int unsigned WORD_W   = 2 * FIELD_W;
  localparam int unsigned NUM_SRC  = 5;
  localparam logic [FIELD_W-1:0] SEL_X    = 8'd0;
  localparam logic [FIELD_W-1:0] SEL_Y    = 8'd1;
  localparam logic [FIELD_W-1:0] SEL_Z    = 8'd2;
  localparam logic [FIELD_W-1:0] SEL_S    = 8'd3;
  localparam logic [FIELD_W-1:0] SEL_BIDX = 8'd4;
  localparam logic [FIELD_W-1:0] SEL_OFF  = 8'hff;

  typedef struct packed {
    logic [FIELD_W-1:0] sel;
    logic [FIELD_W-1:0] ord;
  } eq_term_t;

  function automatic eq_term_t word_to_term(logic [WORD_W-1:0] w);
    eq_term_t t;
    t.sel = w[WORD_W-1:FIELD_W];
    t.ord = w[FIELD_W-1:0];
    return t;
  endfunction
endpackage

// File: rtl/meta_eq_table.sv
module meta_eq_table
  import meta_addr_pkg::*;
#(
  parameter int unsigned MAX_BITS = 32,
  localparam int unsigned BIT_W   = $clog2(MAX_BITS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic                lock_i,
  input  logic [BIT_W-1:0]    bit_i,
  input  logic [2:0]          term_i,
  input  logic [WORD_W-1:0]   word_i,
  output eq_term_t [MAX_BITS-1:0][TERMS-1:0] tbl_o
);
  eq_term_t wr_term;
  logic     wr_ok;

  assign wr_term = word_to_term(word_i);
  assign wr_ok   = we_i && !lock_i;

  for (genvar b = 0; b < MAX_BITS; b++) begin : g_bit
    for (genvar t = 0; t < TERMS; t++) begin : g_term
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          tbl_o[b][t] <= '{sel: SEL_OFF, ord: '0};
        end else if (wr_ok && bit_i == BIT_W'(b) && term_i == 3'(t)) begin
          tbl_o[b][t] <= wr_term;
        end
      end
    end
  end
endmodule

// File: rtl/meta_blk_index.sv
module meta_blk_index #(
  parameter int unsigned COORD_W = 16,
  parameter int unsigned LOG_W   = 4,
  parameter int unsigned IDX_W   = 32
) (
  input  logic [COORD_W-1:0] x_i,
  input  logic [COORD_W-1:0] y_i,
  input  logic [COORD_W-1:0] z_i,
  input  logic [LOG_W-1:0]   w_log2_i,
  input  logic [LOG_W-1:0]   h_log2_i,
  input  logic [LOG_W-1:0]   d_log2_i,
  input  logic [COORD_W-1:0] pitch_i,
  input  logic [COORD_W-1:0] height_i,
  output logic [IDX_W-1:0]   bidx_o
);
  logic [IDX_W-1:0] xb, yb, zb, pb, hb, slice_sz;

  always_comb begin
    xb       = IDX_W'(x_i >> w_log2_i);
    yb       = IDX_W'(y_i >> h_log2_i);
    zb       = IDX_W'(z_i >> d_log2_i);
    pb       = IDX_W'(pitch_i >> w_log2_i);
    hb       = IDX_W'(height_i >> h_log2_i);
    slice_sz = hb * pb;
    bidx_o   = zb * slice_sz + yb * pb + xb;
  end
endmodule

// File: rtl/meta_term_eval.sv
module meta_term_eval
  import meta_addr_pkg::*;
#(
  parameter int unsigned MAX_BITS = 32,
  parameter int unsigned SRC_W    = 32
) (
  input  logic [NUM_SRC-1:0][SRC_W-1:0]       src_i,
  input  eq_term_t [MAX_BITS-1:0][TERMS-1:0]  tbl_i,
  output logic [MAX_BITS-1:0]                 parity_o
);
  localparam int unsigned OSEL_W = $clog2(SRC_W);

  function automatic logic term_bit(logic [NUM_SRC-1:0][SRC_W-1:0] s, eq_term_t t);
    logic [SRC_W-1:0] v;
    logic             in_range;
    in_range = (t.ord < FIELD_W'(SRC_W));
    case (t.sel)
      SEL_X:    v = s[0];
      SEL_Y:    v = s[1];
      SEL_Z:    v = s[2];
      SEL_S:    v = s[3];
      SEL_BIDX: v = s[4];
      default:  v = '0;
    endcase
    return in_range & v[t.ord[OSEL_W-1:0]];
  endfunction

  for (genvar b = 0; b < MAX_BITS; b++) begin : g_bit
    always_comb begin
      parity_o[b] = 1'b0;
      for (int t = 0; t < TERMS; t++) begin
        parity_o[b] = parity_o[b] ^ term_bit(src_i, tbl_i[b][t]);
      end
    end
  end
endmodule

// File: rtl/meta_addr_gen.sv
module meta_addr_gen
  import meta_addr_pkg::*;
#(
  parameter int unsigned MAX_BITS = 32,
  parameter int unsigned COORD_W  = 16,
  parameter int unsigned LOG_W    = 4,
  parameter int unsigned PIPE_W   = 8,
  parameter int unsigned PBITS_W  = 4,
  parameter int unsigned ILV_W    = 3,
  parameter int unsigned ILV_BASE = 8,
  localparam int unsigned ADDR_W  = 32,
  localparam int unsigned BIT_W   = $clog2(MAX_BITS),
  localparam int unsigned NB_W    = $clog2(MAX_BITS + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               eq_we_i,
  input  logic [BIT_W-1:0]   eq_bit_i,
  input  logic [2:0]         eq_term_i,
  input  logic [15:0]        eq_word_i,
  input  logic               in_valid_i,
  input  logic [COORD_W-1:0] x_i,
  input  logic [COORD_W-1:0] y_i,
  input  logic [COORD_W-1:0] z_i,
  input  logic [COORD_W-1:0] sample_i,
  input  logic [LOG_W-1:0]   blk_w_log2_i,
  input  logic [LOG_W-1:0]   blk_h_log2_i,
  input  logic [LOG_W-1:0]   blk_d_log2_i,
  input  logic [COORD_W-1:0] pitch_i,
  input  logic [COORD_W-1:0] height_i,
  input  logic [PIPE_W-1:0]  pipe_xor_i,
  input  logic [PBITS_W-1:0] pipe_bits_i,
  input  logic [ILV_W-1:0]   ilv_i,
  input  logic [NB_W-1:0]    num_bits_i,
  output logic               out_valid_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [2:0]         nibble_o
);
  eq_term_t [MAX_BITS-1:0][TERMS-1:0] tbl;
  logic [ADDR_W-1:0]                  bidx;
  logic [NUM_SRC-1:0][ADDR_W-1:0]     src;
  logic [MAX_BITS-1:0]                parity;

  meta_eq_table #(.MAX_BITS(MAX_BITS)) i_table (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (eq_we_i),
    .lock_i (in_valid_i),
    .bit_i  (eq_bit_i),
    .term_i (eq_term_i),
    .word_i (eq_word_i),
    .tbl_o  (tbl)
  );

  meta_blk_index #(.COORD_W(COORD_W), .LOG_W(LOG_W), .IDX_W(ADDR_W)) i_bidx (
    .x_i      (x_i),
    .y_i      (y_i),
    .z_i      (z_i),
    .w_log2_i (blk_w_log2_i),
    .h_log2_i (blk_h_log2_i),
    .d_log2_i (blk_d_log2_i),
    .pitch_i  (pitch_i),
    .height_i (height_i),
    .bidx_o   (bidx)
  );

  assign src[0] = ADDR_W'(x_i);
  assign src[1] = ADDR_W'(y_i);
  assign src[2] = ADDR_W'(z_i);
  assign src[3] = ADDR_W'(sample_i);
  assign src[4] = bidx;

  meta_term_eval #(.MAX_BITS(MAX_BITS), .SRC_W(ADDR_W)) i_eval (
    .src_i    (src),
    .tbl_i    (tbl),
    .parity_o (parity)
  );

  // Combine: parity below the top bit, shifted block index from it upward.
  logic [NB_W-1:0]    nb_eff;
  logic [BIT_W-1:0]   top_idx;
  logic [FIELD_W-1:0] top_ord;
  logic [ADDR_W-1:0]  low_mask, raw, hi_part;
  logic [PIPE_W-1:0]  pmask;
  logic [ADDR_W-1:0]  pipe_sh, addr_nxt;

  always_comb begin
    if (num_bits_i == '0)                       nb_eff = NB_W'(1);
    else if (num_bits_i > NB_W'(MAX_BITS))      nb_eff = NB_W'(MAX_BITS);
    else                                        nb_eff = num_bits_i;
    top_idx  = BIT_W'(nb_eff - NB_W'(1));
    top_ord  = tbl[top_idx][0].ord;
    low_mask = (ADDR_W'(1) << top_idx) - ADDR_W'(1);
    hi_part  = (top_ord >= FIELD_W'(ADDR_W)) ? '0 : ((bidx >> top_ord) << top_idx);
    raw      = (ADDR_W'(parity) & low_mask) | hi_part;
    pmask    = (pipe_bits_i >= PBITS_W'(PIPE_W)) ? '1
             : PIPE_W'((PIPE_W'(1) << pipe_bits_i) - PIPE_W'(1));
    pipe_sh  = ADDR_W'(pipe_xor_i & pmask) << (ILV_BASE + 32'(ilv_i));
    addr_nxt = (raw >> 1) ^ pipe_sh;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      addr_o      <= '0;
      nibble_o    <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        addr_o   <= addr_nxt;
        nibble_o <= {raw[0], 2'b00};
      end
    end
  end
endmodule

// File: rtl/meta_addr_gen_chk.sv
module meta_addr_gen_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        in_valid_i,
  input logic        out_valid_o,
  input logic [31:0] addr_o,
  input logic [2:0]  nibble_o
);
  a_r8_valid_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);

  a_r8_valid_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> ($stable(addr_o) && $stable(nibble_o)));

  a_r6_nibble_enc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nibble_o == 3'd0) || (nibble_o == 3'd4));

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r9_reset_clear: assert (!out_valid_o && addr_o == '0 && nibble_o == '0);
    end
  end
endmodule

bind meta_addr_gen meta_addr_gen_chk i_chk (.*);

// File: tb/test_meta_addr_gen.sv
module test_meta_addr_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        eq_we_i = 1'b0;
  logic [4:0]  eq_bit_i = '0;
  logic [2:0]  eq_term_i = '0;
  logic [15:0] eq_word_i = '0;
  logic        in_valid_i = 1'b0;
  logic [15:0] x_i = '0, y_i = '0, z_i = '0, sample_i = '0;
  logic [3:0]  blk_w_log2_i = '0, blk_h_log2_i = '0, blk_d_log2_i = '0;
  logic [15:0] pitch_i = '0, height_i = '0;
  logic [7:0]  pipe_xor_i = '0;
  logic [3:0]  pipe_bits_i = '0;
  logic [2:0]  ilv_i = '0;
  logic [5:0]  num_bits_i = 6'd1;
  logic        out_valid_o;
  logic [31:0] addr_o;
  logic [2:0]  nibble_o;

  meta_addr_gen i_meta_addr_gen (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int checks = 0, fails = 0;
  string cur_req = "R9";
  int m_sel [32][5];
  int m_ord [32][5];
  bit        e_v;
  bit [31:0] e_a;
  bit [2:0]  e_n;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h @%0t", req, act, exp, $time);
    end
  endtask

  // Behavioural model of the requirement formulas
  function automatic void ref_calc(output bit [31:0] a, output bit [2:0] nib);
    int nb;
    bit [31:0] c[5];
    bit [31:0] raw, bidx, pb, hb, xb, yb, zb;
    bit [7:0]  mask;
    nb = (num_bits_i == 0) ? 1 : (num_bits_i > 32 ? 32 : int'(num_bits_i));
    pb = 32'(pitch_i >> blk_w_log2_i);
    hb = 32'(height_i >> blk_h_log2_i);
    xb = 32'(x_i >> blk_w_log2_i);
    yb = 32'(y_i >> blk_h_log2_i);
    zb = 32'(z_i >> blk_d_log2_i);
    bidx = zb * (hb * pb) + yb * pb + xb;
    c[0] = 32'(x_i); c[1] = 32'(y_i); c[2] = 32'(z_i); c[3] = 32'(sample_i); c[4] = bidx;
    raw = 0;
    for (int b = 0; b < nb - 1; b++) begin
      bit v = 0;
      for (int t = 0; t < 5; t++)
        if (m_sel[b][t] < 5 && m_ord[b][t] < 32) v ^= c[m_sel[b][t]][m_ord[b][t]];
      raw[b] = v;
    end
    if (m_ord[nb-1][0] < 32) raw |= (bidx >> m_ord[nb-1][0]) << (nb - 1);
    nib = raw[0] ? 3'd4 : 3'd0;
    mask = (pipe_bits_i >= 8) ? 8'hff : 8'((1 << pipe_bits_i) - 1);
    a = (raw >> 1) ^ (32'(pipe_xor_i & mask) << (8 + ilv_i));
  endfunction

  // Cycle-by-cycle comparison
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      e_v = 0; e_a = 0; e_n = 0;
    end else begin
      e_v = in_valid_i;
      if (in_valid_i) ref_calc(e_a, e_n);
      if (eq_we_i && !in_valid_i && eq_term_i < 5) begin
        m_sel[eq_bit_i][eq_term_i] = int'(eq_word_i[15:8]);
        m_ord[eq_bit_i][eq_term_i] = int'(eq_word_i[7:0]);
      end
    end
    #2;
    if (rst_ni) begin
      check(out_valid_o == e_v, "R8 valid", out_valid_o, e_v);
      check(addr_o == e_a, cur_req, addr_o, e_a);
      check(nibble_o == e_n, "R6 nibble", nibble_o, e_n);
    end
  end

  task automatic wr(input int b, input int t, input int sel, input int ord);
    eq_we_i = 1; eq_bit_i = 5'(b); eq_term_i = 3'(t); eq_word_i = {8'(sel), 8'(ord)};
    @(negedge clk_i);
    eq_we_i = 0;
  endtask

  task automatic req(input int x, input int y, input int z, input int s);
    x_i = 16'(x); y_i = 16'(y); z_i = 16'(z); sample_i = 16'(s);
    in_valid_i = 1;
    @(negedge clk_i);
    in_valid_i = 0;
  endtask

  task automatic clear_eq();
    for (int b = 0; b < 32; b++)
      for (int t = 0; t < 5; t++) wr(b, t, 255, 0);
  endtask

  initial begin
    bit [31:0] a0, a1, ea;
    bit [2:0]  en;
    for (int b = 0; b < 32; b++)
      for (int t = 0; t < 5; t++) begin m_sel[b][t] = 255; m_ord[b][t] = 0; end
    repeat (3) @(negedge clk_i);
    check(out_valid_o == 0 && addr_o == 0 && nibble_o == 0, "R9 reset", {addr_o, nibble_o, out_valid_o}, 0);
    rst_ni = 1;
    @(negedge clk_i);

    // Short hand-built equation, full sweep (R1, R3, R4, R5, R6, R11)
    cur_req = "R4";
    wr(0, 0, 0, 0);
    wr(1, 0, 3, 0);
    wr(2, 0, 0, 1); wr(2, 1, 1, 0);
    wr(3, 0, 1, 1); wr(3, 1, 2, 0); wr(3, 2, 0, 3);
    wr(4, 0, 0, 2); wr(4, 1, 6, 0); wr(4, 2, 4, 1);
    wr(5, 0, 9, 2);
    num_bits_i = 6; blk_w_log2_i = 2; blk_h_log2_i = 2; blk_d_log2_i = 0;
    pitch_i = 16; height_i = 8; pipe_xor_i = 8'h5a; pipe_bits_i = 3; ilv_i = 1;
    for (int z = 0; z < 2; z++)
      for (int y = 0; y < 8; y++)
        for (int x = 0; x < 16; x++)
          for (int s = 0; s < 2; s++) req(x, y, z, s);

    cur_req = "R11";
    for (int k = 0; k < 8; k++) begin
      req(3 * k, k, k & 1, 0); a0 = addr_o;
      req(3 * k, k, k & 1, 1); a1 = addr_o;
      check(a1 == a0 + 1, "R11 sample adjacency", a1, a0 + 1);
    end

    // R2: write in the same cycle as a request is dropped
    cur_req = "R2";
    eq_we_i = 1; eq_bit_i = 0; eq_term_i = 0; eq_word_i = {8'd1, 8'd0};
    req(1, 0, 0, 0);
    eq_we_i = 0;
    req(1, 0, 0, 0);
    check(nibble_o == 3'd4, "R2 write ignored during request", nibble_o, 4);

    // R1: term slot beyond 4 changes nothing
    cur_req = "R1";
    wr(0, 6, 1, 0);
    wr(0, 5, 1, 0);
    req(1, 0, 0, 0);
    check(nibble_o == 3'd4, "R1 term slot 5..7 ignored", nibble_o, 4);
    wr(0, 0, 1, 0);
    req(1, 0, 0, 0);
    check(nibble_o == 3'd0, "R1 write to term 0 takes effect", nibble_o, 0);

    // R10: bit count limits
    cur_req = "R10";
    pipe_bits_i = 0;
    num_bits_i = 0; req(20, 5, 1, 0); a0 = addr_o;
    num_bits_i = 1; req(20, 5, 1, 0); a1 = addr_o;
    check(a0 == a1, "R10 zero acts as one", a0, a1);
    clear_eq();
    wr(31, 0, 255, 3);
    num_bits_i = 40; req(50, 6, 1, 1); a0 = addr_o;
    num_bits_i = 32; req(50, 6, 1, 1); a1 = addr_o;
    check(a0 == a1, "R10 above 32 acts as 32", a0, a1);

    // R7: pipe mask and interleave
    cur_req = "R7";
    num_bits_i = 1; wr(0, 0, 0, 63);
    x_i = 0; y_i = 0; z_i = 0; pitch_i = 0; height_i = 0;
    for (int pb = 0; pb < 12; pb += 3)
      for (int il = 0; il < 8; il += 7) begin
        pipe_xor_i = 8'hff; pipe_bits_i = 4'(pb); ilv_i = 3'(il);
        req(0, 0, 0, 0);
        ea = (pb >= 8 ? 32'hff : 32'((1 << pb) - 1)) << (8 + il);
        check(addr_o == ea, "R7 pipe mask/interleave", addr_o, ea);
      end

    // R8: result holds over idle cycles
    cur_req = "R8";
    a0 = addr_o;
    repeat (4) @(negedge clk_i);
    check(addr_o == a0 && !out_valid_o, "R8 hold when idle", addr_o, a0);

    // R3/R5: random 32-bit equation with block-index terms
    cur_req = "R5";
    void'($urandom(17));
    for (int b = 0; b < 32; b++)
      for (int t = 0; t < 5; t++) wr(b, t, $urandom_range(0, 6), $urandom_range(0, 31));
    for (int n = 0; n < 300; n++) begin
      num_bits_i = 6'($urandom_range(1, 32));
      blk_w_log2_i = 4'($urandom_range(0, 4)); blk_h_log2_i = 4'($urandom_range(0, 4));
      blk_d_log2_i = 4'($urandom_range(0, 2));
      pitch_i = 16'($urandom); height_i = 16'($urandom);
      pipe_xor_i = 8'($urandom); pipe_bits_i = 4'($urandom_range(0, 9)); ilv_i = 3'($urandom);
      cur_req = (n % 2 == 0) ? "R3" : "R5";
      req($urandom, $urandom, $urandom, $urandom_range(0, 7));
    end
    num_bits_i = 32; pitch_i = 16'hffff; height_i = 16'hffff;
    blk_w_log2_i = 0; blk_h_log2_i = 0; blk_d_log2_i = 0;
    req(16'hffff, 16'hffff, 16'hffff, 0);
    ref_calc(ea, en);
    check(addr_o == ea, "R3 block index wraps", addr_o, ea);

    repeat (2) @(negedge clk_i);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule